// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block is the digital control store for a matrix of 4 rows by 8 columns of crosspoint switches. Each of its 32 storage cells drives one switch enable, and a 1 in a cell turns that switch on. A write names one cell with a row address and a column address and supplies one data bit. Chip select and strobe gate the write, so several matrices can share the same address, data and strobe wires.

The write is level-sensitive. While chip select and strobe are both high, the addressed enable output follows `data_i` combinationally. The cell captures the data on every clock edge of the write. When the write ends, the value from the last enabled edge is held. The active-low master reset clears every cell at once, whatever chip select, strobe, address and data are doing, and it overrides a write that is in progress.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `rst_ni` is low, every bit of `sw_en_o` is 0 at once, with no clock edge needed, whatever `cs_i`, `strobe_i`, the address and `data_i` are.
- R2: Cell (row, column) drives `sw_en_o[row*8 + column]`. Row 0, column 1 is bit 1 and row 3, column 7 is bit 31. A stored 1 makes the bit high (switch on) and a stored 0 makes it low (switch off).
- R3: A write takes effect only when `rst_ni`, `cs_i` and `strobe_i` are all high. With `cs_i` low or `strobe_i` low, `sw_en_o` keeps its previous value.
- R4: While a write is enabled, the addressed bit of `sw_en_o` equals `data_i` in the same cycle and follows every change of `data_i`.
- R5: Once the write is disabled (strobe falls or chip select drops), the addressed cell holds the `data_i` value it sampled at the last rising clock edge at which the write was enabled.
- R6: A write changes only the addressed bit. All other bits of `sw_en_o` keep their values.
- R7: A reset asserted in the middle of an enabled write wins. The output is all zeros during the reset, and once the reset is released with the write disabled, no value from the interrupted write appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples writes into the cells |
| rst_ni | input | 1 | Active-low asynchronous master reset; clears all cells |
| row_addr_i | input | 2 | Row select, 0 to 3 |
| col_addr_i | input | 3 | Column select, 0 to 7 |
| data_i | input | 1 | Value to write: 1 turns the switch on, 0 turns it off |
| cs_i | input | 1 | Chip select, active high |
| strobe_i | input | 1 | Write strobe, active high |
| sw_en_o | output | 32 | Switch enables, indexed row*8 + column |

## Verification
The assertions check four behaviours on every cycle:
- the addressed output tracks `data_i` during a write (R4);
- every output bit outside the addressed cell stays stable (R6);
- the whole vector holds while the write is disabled (R3);
- the last enabled data value remains after the write ends (R5).

Clearing without a clock edge, and the precedence of reset over a write that is in progress, show only in the bench's directed scenarios, which sample between clock edges. The same applies to the row-major bit mapping at the corners of the matrix and to chip-select gating against an array model.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
  parameter int unsigned XPT_ROWS = 4;
  parameter int unsigned XPT_COLS = 8;

  // flat row-major cell index
  function automatic int unsigned xpt_flat_idx(int unsigned row, int unsigned col,
                                               int unsigned cols);
    return row * cols + col;
  endfunction
endpackage

// File: rtl/xpt_addr_dec.sv
`timescale 1ns/1ps
module xpt_addr_dec #(
  parameter int unsigned ROWS   = xpt_pkg::XPT_ROWS,
  parameter int unsigned COLS   = xpt_pkg::XPT_COLS,
  localparam int unsigned RAW   = $clog2(ROWS),
  localparam int unsigned CAW   = $clog2(COLS),
  localparam int unsigned CELLS = ROWS * COLS
) (
  input  logic [RAW-1:0]   row_addr_i,
  input  logic [CAW-1:0]   col_addr_i,
  output logic [CELLS-1:0] sel_o
);
  logic [ROWS-1:0] row_hit;
  logic [COLS-1:0] col_hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_hit[r] = (row_addr_i == RAW'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_hit[c] = (col_addr_i == CAW'(c));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_sel_r
    for (genvar c = 0; c < COLS; c++) begin : g_sel_c
      assign sel_o[xpt_pkg::xpt_flat_idx(r, c, COLS)] = row_hit[r] & col_hit[c];
    end
  end
endmodule

// File: rtl/xpt_wr_gate.sv
`timescale 1ns/1ps
module xpt_wr_gate #(
  parameter int unsigned CELLS = xpt_pkg::XPT_ROWS * xpt_pkg::XPT_COLS
) (
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             strobe_i,
  input  logic [CELLS-1:0] sel_i,
  output logic [CELLS-1:0] wr_en_o
);
  logic wr_ok;

  // reset blocks the write path so the clear cannot be overridden
  assign wr_ok   = rst_ni & cs_i & strobe_i;
  assign wr_en_o = sel_i & {CELLS{wr_ok}};
endmodule

// File: rtl/xpt_cell.sv
`timescale 1ns/1ps
module xpt_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic data_i,
  output logic state_o
);
  logic held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= 1'b0;
    else if (wr_en_i) held_q <= data_i;
  end

  // transparent while written
  assign state_o = wr_en_i ? data_i : held_q;
endmodule

// File: rtl/xpt_ctrl_mem.sv
`timescale 1ns/1ps
module xpt_ctrl_mem #(
  parameter int unsigned ROWS   = xpt_pkg::XPT_ROWS,
  parameter int unsigned COLS   = xpt_pkg::XPT_COLS,
  localparam int unsigned RAW   = $clog2(ROWS),
  localparam int unsigned CAW   = $clog2(COLS),
  localparam int unsigned CELLS = ROWS * COLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAW-1:0]   row_addr_i,
  input  logic [CAW-1:0]   col_addr_i,
  input  logic             data_i,
  input  logic             cs_i,
  input  logic             strobe_i,
  output logic [CELLS-1:0] sw_en_o
);
  logic [CELLS-1:0] sel;
  logic [CELLS-1:0] wr_en;

  xpt_addr_dec #(.ROWS(ROWS), .COLS(COLS)) u_dec (
    .row_addr_i (row_addr_i),
    .col_addr_i (col_addr_i),
    .sel_o      (sel)
  );

  xpt_wr_gate #(.CELLS(CELLS)) u_gate (
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .strobe_i (strobe_i),
    .sel_i    (sel),
    .wr_en_o  (wr_en)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    xpt_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en[i]),
      .data_i  (data_i),
      .state_o (sw_en_o[i])
    );
  end
endmodule

// File: rtl/xpt_ctrl_mem_chk.sv
`timescale 1ns/1ps
module xpt_ctrl_mem_chk #(
  parameter int unsigned ROWS   = xpt_pkg::XPT_ROWS,
  parameter int unsigned COLS   = xpt_pkg::XPT_COLS,
  localparam int unsigned RAW   = $clog2(ROWS),
  localparam int unsigned CAW   = $clog2(COLS),
  localparam int unsigned CELLS = ROWS * COLS,
  localparam int unsigned IW    = $clog2(CELLS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RAW-1:0]   row_addr_i,
  input logic [CAW-1:0]   col_addr_i,
  input logic             data_i,
  input logic             cs_i,
  input logic             strobe_i,
  input logic [CELLS-1:0] sw_en_o
);
  logic [IW-1:0]    idx;
  logic             wr_act;
  logic [CELLS-1:0] idx_mask;

  assign idx      = IW'(row_addr_i) * IW'(COLS) + IW'(col_addr_i);
  assign wr_act   = cs_i & strobe_i;
  assign idx_mask = CELLS'(1) << idx;

  // R4
  transparent_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_act |-> sw_en_o[idx] == data_i);

  // R6
  others_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_act |-> ((sw_en_o ^ $past(sw_en_o)) & ~idx_mask) == '0);

  // R3
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_act |-> sw_en_o == $past(sw_en_o));

  // R5
  capture_on_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_act) && $past(rst_ni) && !wr_act) |-> sw_en_o[$past(idx)] == $past(data_i));
endmodule

bind xpt_ctrl_mem xpt_ctrl_mem_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/xpt_ctrl_mem_tb.sv
`timescale 1ns/1ps
module xpt_ctrl_mem_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   row = '0;
  logic [2:0]   col = '0;
  logic         dat = 1'b0;
  logic         cs = 1'b0;
  logic         stb = 1'b0;
  logic [N-1:0] sw;

  logic [N-1:0] ref_q = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xpt_ctrl_mem u_dut (
    .clk_i(clk), .rst_ni(rst_n), .row_addr_i(row), .col_addr_i(col),
    .data_i(dat), .cs_i(cs), .strobe_i(stb), .sw_en_o(sw)
  );

  function automatic logic [N-1:0] expect_out(logic r, logic [1:0] ra, logic [2:0] ca,
                                              logic d, logic c, logic s, logic [N-1:0] q);
    logic [N-1:0] v;
    if (!r) return '0;
    v = q;
    if (c && s) v[ra*8 + ca] = d;
    return v;
  endfunction

  task automatic check(string req);
    logic [N-1:0] e;
    e = expect_out(rst_n, row, col, dat, cs, stb, ref_q);
    checks++;
    if (sw !== e) begin
      errors++;
      $display("FAIL %s: sw_en_o=%h expected=%h", req, sw, e);
    end
  endtask

  // drive at negedge, check mid-low phase, update model after posedge
  task automatic apply(logic r, logic [1:0] ra, logic [2:0] ca, logic d,
                       logic c, logic s, string req);
    @(negedge clk);
    rst_n = r; row = ra; col = ca; dat = d; cs = c; stb = s;
    #3 check(req);
    @(posedge clk);
    #1;
    if (!r) ref_q = '0;
    else if (c && s) ref_q[ra*8 + ca] = d;
  endtask

  task automatic check_bit(int b, logic v, string req);
    checks++;
    if (sw[b] !== v) begin
      errors++;
      $display("FAIL %s: sw_en_o[%0d]=%b expected=%b", req, b, sw[b], v);
    end
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    // R1: reset with an active write request
    apply(1'b0, 2'd2, 3'd5, 1'b1, 1'b1, 1'b1, "R1");
    apply(1'b0, 2'd0, 3'd0, 1'b1, 1'b1, 1'b1, "R1");
    apply(1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, "R1");

    // R2: corner mapping
    apply(1'b1, 2'd0, 3'd1, 1'b1, 1'b1, 1'b1, "R2");
    apply(1'b1, 2'd0, 3'd1, 1'b1, 1'b1, 1'b0, "R2");
    #3 check_bit(1, 1'b1, "R2");
    apply(1'b1, 2'd3, 3'd7, 1'b1, 1'b1, 1'b1, "R2");
    apply(1'b1, 2'd3, 3'd7, 1'b1, 1'b1, 1'b0, "R2");
    #3 check_bit(31, 1'b1, "R2");

    // R4: data toggles while strobe high; R5: last enabled value held
    apply(1'b1, 2'd2, 3'd4, 1'b1, 1'b1, 1'b1, "R4");
    #3 check_bit(20, 1'b1, "R4");
    apply(1'b1, 2'd2, 3'd4, 1'b0, 1'b1, 1'b1, "R4");
    #3 check_bit(20, 1'b0, "R4");
    apply(1'b1, 2'd2, 3'd4, 1'b1, 1'b1, 1'b1, "R4");
    apply(1'b1, 2'd2, 3'd4, 1'b0, 1'b1, 1'b1, "R4");
    apply(1'b1, 2'd2, 3'd4, 1'b1, 1'b1, 1'b0, "R5");
    #3 check_bit(20, 1'b0, "R5");

    // R3: chip select low, strobe high -> ignored
    apply(1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b1, "R3");
    apply(1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, "R3");
    #3 check_bit(1, 1'b1, "R3");

    // R6: writing one cell leaves neighbours alone
    apply(1'b1, 2'd1, 3'd0, 1'b1, 1'b1, 1'b1, "R6");
    apply(1'b1, 2'd1, 3'd0, 1'b1, 1'b0, 1'b0, "R6");
    #3 check_bit(8, 1'b1, "R6");
    #0 check_bit(1, 1'b1, "R6");

    // R7: reset in the middle of a strobe
    apply(1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b1, "R7");
    apply(1'b0, 2'd1, 3'd3, 1'b1, 1'b1, 1'b1, "R7");
    apply(1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, "R7");
    #3 check_bit(11, 1'b0, "R7");

    // random mix: R3 R4 R5 R6 against the array model
    for (int i = 0; i < 600; i++) begin
      apply(($urandom_range(39) != 0), 2'($urandom), 3'($urandom), 1'($urandom),
            ($urandom_range(3) != 0), 1'($urandom), "R3 R4 R5 R6");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule